// File: doc/BRIEF.md
# Serial Shift Slice

A single serial input/output slice for a general-purpose serial I/O engine. A 32-bit working register moves data to the right on every shift tick. Fresh bits enter at the top of the register and outgoing bits leave at the bottom. Each tick moves 1, 2, 4 or 8 bits, and the eight parallel lanes `serIn` and `serOut` carry those bits. A programmable prescaler derives the shift tick from the input clock.

A down-counting position counter decides when a word is complete. On the tick where the counter is at zero, the freshly shifted word goes to a shadow register, and the previous shadow contents move into the working register. Software can therefore read the shadow register, or refill it, at any moment without stalling the stream. Several slices can act as one longer chain when each position preset is set to 32 times the chain length, minus 1.

Configuration uses a simple write port. The shadow register is always visible on a parallel output. A one-cycle pulse marks every exchange, so that a later event stage can use it.

Top module: `shift_slice`

## Requirements
- R1: After reset `serOut`, `shadowRd`, `shiftTick` and `swapPulse` are all 0, and the slice is disabled.
- R2: While enabled with prescale value P, `shiftTick` is high for one cycle in every P+1 cycles. The first tick comes P+1 cycles after the cycle in which the enabling write is applied.
- R3: While disabled, `shiftTick` stays low, `serOut` and `shadowRd` do not move, and the prescale count is held at P. A write to address 0 with bit 0 cleared stops ticks from the next cycle on.
- R4: On each tick the working register shifts right. `serOut` always shows its low 8 bits, and between ticks `serOut` holds its value.
- R5: The width field (address 0, bits [2:1]) selects the bits moved per tick: 00 is 1 bit, 01 is 2 bits, 10 is 4 bits, 11 is 8 bits. For width w, `serIn[w-1:0]` fills bits [31:32-w], with `serIn[w-1]` at bit 31.
- R6: The position count drops by 1 on each tick. On a tick where it is 0, it reloads from the position preset and the exchange takes place, so exchanges occur every preset+1 ticks (32*k-1 for k chained 1-bit slices).
- R7: At an exchange the shadow register receives the word as shifted on that tick, and the working register receives the previous shadow contents.
- R8: `swapPulse` is high for exactly the one cycle after each exchanging tick, the cycle in which the exchanged values first appear.
- R9: A write to address 3 loads the shadow register, which shows the value on `shadowRd` in the next cycle. This write does not change the shift in progress.
- R10: If a shadow write and an exchange fall in the same cycle, the exchange wins, and the written value is discarded.
- R11: A write to address 2 sets the position preset from bits [15:8] and the current count from bits [7:0]. A write to address 1 sets the prescale value from bits [PRE_W-1:0]. A position write overrides a same-cycle tick update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 control, 1 prescale, 2 position, 3 shadow |
| wrData | input | DATA_W | Write data |
| serIn | input | 8 | Incoming serial lanes |
| serOut | output | 8 | Outgoing serial lanes (low bits of the working register) |
| shadowRd | output | DATA_W | Current shadow register contents |
| shiftTick | output | 1 | High in each cycle in which a shift takes place |
| swapPulse | output | 1 | One-cycle marker of an exchange |

## Verification
The bench builds the slice with its defaults: DATA_W=32, an 8-bit position field and a 12-bit prescale field. At these sizes a full 1-bit word takes 32 ticks, and a four-slice chained preset of 127 finishes within a few hundred cycles. Prescale values 0 to 3 cover both back-to-back ticks and spaced ticks. A position preset of 0 gives an exchange on every tick, which makes shadow writes collide with exchanges on purpose and so reaches the priority case.

// File: rtl/slice_pkg.sv
package slice_pkg;
  localparam int LANES = 8;
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_PRESC  = 2'd1;
  localparam logic [1:0] ADDR_POS    = 2'd2;
  localparam logic [1:0] ADDR_SHADOW = 2'd3;

  // Strobes from control to datapath
  typedef struct packed {
    logic       tick;
    logic       swap;
    logic [1:0] widthSel;
  } sliceStrobe_t;
endpackage

// File: rtl/slice_ctrl.sv
module slice_ctrl
  import slice_pkg::*;
#(
  parameter int PRE_W = 12,
  parameter int POS_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrAddr,
  input  logic [2*POS_W-1:0] cfgData,
  output sliceStrobe_t       ctl
);
  logic             enQ;
  logic [1:0]       widthQ;
  logic [PRE_W-1:0] presetQ;
  logic [PRE_W-1:0] preCnt;
  logic [POS_W-1:0] posPreQ;
  logic [POS_W-1:0] posCnt;
  logic             tick;

  assign tick         = enQ && (preCnt == '0);
  assign ctl.tick     = tick;
  assign ctl.swap     = tick && (posCnt == '0);
  assign ctl.widthSel = widthQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ     <= 1'b0;
      widthQ  <= 2'b00;
      presetQ <= '0;
      preCnt  <= '0;
      posPreQ <= '0;
      posCnt  <= '0;
    end else begin
      if (!enQ || preCnt == '0) preCnt <= presetQ;
      else                      preCnt <= preCnt - 1'b1;

      if (tick) posCnt <= (posCnt == '0) ? posPreQ : posCnt - 1'b1;

      if (wrEn) begin
        case (wrAddr)
          ADDR_CTRL: begin
            enQ    <= cfgData[0];
            widthQ <= cfgData[2:1];
          end
          ADDR_PRESC: presetQ <= cfgData[PRE_W-1:0];
          ADDR_POS: begin
            posPreQ <= cfgData[2*POS_W-1:POS_W];
            posCnt  <= cfgData[POS_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/slice_datapath.sv
module slice_datapath
  import slice_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  sliceStrobe_t      ctl,
  input  logic              shadowWr,
  input  logic [DATA_W-1:0] shadowWrData,
  input  logic [LANES-1:0]  serIn,
  output logic [LANES-1:0]  serOut,
  output logic [DATA_W-1:0] shadowRd,
  output logic              swapPulse
);
  localparam int NUM_W = 4;

  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] shadowQ;
  logic [DATA_W-1:0] cand [NUM_W];
  logic [DATA_W-1:0] shifted;

  // one candidate per width 1, 2, 4, 8
  for (genvar g = 0; g < NUM_W; g++) begin : g_width
    localparam int W = 1 << g;
    assign cand[g] = {serIn[W-1:0], dataQ[DATA_W-1:W]};
  end

  assign shifted  = cand[ctl.widthSel];
  assign serOut   = dataQ[LANES-1:0];
  assign shadowRd = shadowQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ     <= '0;
      shadowQ   <= '0;
      swapPulse <= 1'b0;
    end else begin
      if (ctl.tick) dataQ <= ctl.swap ? shadowQ : shifted;
      if (ctl.swap)      shadowQ <= shifted;
      else if (shadowWr) shadowQ <= shadowWrData;
      swapPulse <= ctl.swap;
    end
  end
endmodule

// File: rtl/shift_slice.sv
module shift_slice
  import slice_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 12,
  parameter int POS_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [7:0]        serIn,
  output logic [7:0]        serOut,
  output logic [DATA_W-1:0] shadowRd,
  output logic              shiftTick,
  output logic              swapPulse
);
  sliceStrobe_t ctl;
  logic         shadowWr;

  assign shadowWr  = wrEn && (wrAddr == ADDR_SHADOW);
  assign shiftTick = ctl.tick;

  slice_ctrl #(.PRE_W(PRE_W), .POS_W(POS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .cfgData(wrData[2*POS_W-1:0]), .ctl(ctl)
  );

  slice_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .shadowWr(shadowWr),
    .shadowWrData(wrData), .serIn(serIn), .serOut(serOut),
    .shadowRd(shadowRd), .swapPulse(swapPulse)
  );
endmodule

// File: rtl/shift_slice_chk.sv
module shift_slice_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        wrAddr,
  input logic              stopBit,
  input logic              shiftTick,
  input logic              swapPulse,
  input logic              swapNow,
  input logic [7:0]        serOut,
  input logic [DATA_W-1:0] shadowRd
);
  // R8
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    swapPulse |-> $past(shiftTick));

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !shiftTick |=> $stable(serOut));

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!swapNow && !(wrEn && wrAddr == 2'd3)) |=> $stable(shadowRd));

  // R3
  stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd0 && !stopBit) |=> !shiftTick);
endmodule

bind shift_slice shift_slice_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
  .stopBit(wrData[0]), .shiftTick(shiftTick), .swapPulse(swapPulse),
  .swapNow(ctl.swap), .serOut(serOut), .shadowRd(shadowRd)
);

// File: tb/sim_shift_slice.sv
module sim_shift_slice;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  serIn = '0;
  logic [7:0]  serOut;
  logic [31:0] shadowRd;
  logic        shiftTick, swapPulse;

  always #5 clk = ~clk;

  shift_slice u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .serIn(serIn), .serOut(serOut), .shadowRd(shadowRd),
    .shiftTick(shiftTick), .swapPulse(swapPulse));

  int checks = 0;
  int errors = 0;
  bit run = 0;
  bit done = 0;
  logic [31:0] expQ [$];

  // reference state derived from the requirements
  logic        mEn = 0, mPulse = 0;
  logic [1:0]  mW = 0;
  logic [11:0] mPre = 0, mCnt = 0;
  logic [7:0]  mPosPre = 0, mPos = 0;
  logic [31:0] mData = 0, mShadow = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(posedge clk); #1;
    wrEn = 1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  // serial input pattern
  initial begin
    logic [15:0] lfsr = 16'hACE1;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      serIn = lfsr[7:0];
    end
  end

  // monitor and scoreboard
  always @(negedge clk) begin
    if (rstN && run) begin
      logic tickExp, swapNow;
      logic [31:0] shifted, ins;
      int w;
      tickExp = mEn && (mCnt == 0);
      chk("R2/R3 shift tick", {31'b0, shiftTick}, {31'b0, tickExp});
      chk("R6/R8/R11 swap pulse", {31'b0, swapPulse}, {31'b0, mPulse});
      chk("R4/R5 serial out", {24'b0, serOut}, {24'b0, mData[7:0]});
      chk("R9/R10 shadow", shadowRd, mShadow);
      if (swapPulse) begin
        if (expQ.size() == 0) chk("R7 unexpected exchange", 32'd1, 32'd0);
        else chk("R7 exchanged word", shadowRd, expQ.pop_front());
      end
      w = 1 << mW;
      ins = ({24'b0, serIn} & ((32'd1 << w) - 1)) << (32 - w);
      shifted = (mData >> w) | ins;
      swapNow = tickExp && (mPos == 0);
      mPulse = swapNow;
      if (tickExp) begin
        if (swapNow) begin
          mData = mShadow;
          mShadow = shifted;
          expQ.push_back(shifted);
          mPos = mPosPre;
        end else begin
          mData = shifted;
          mPos = mPos - 1;
        end
      end
      if (!swapNow && wrEn && wrAddr == 2'd3) mShadow = wrData;
      if (!mEn || mCnt == 0) mCnt = mPre;
      else mCnt = mCnt - 1;
      if (wrEn) begin
        case (wrAddr)
          2'd0: begin mEn = wrData[0]; mW = wrData[2:1]; end
          2'd1: mPre = wrData[11:0];
          2'd2: begin mPosPre = wrData[15:8]; mPos = wrData[7:0]; end
          default: ;
        endcase
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    idle(3);
    #1 rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 serOut", {24'b0, serOut}, 32'd0);
    chk("R1 shadowRd", shadowRd, 32'd0);
    chk("R1 shiftTick", {31'b0, shiftTick}, 32'd0);
    chk("R1 swapPulse", {31'b0, swapPulse}, 32'd0);
    run = 1;
    idle(5); // R3 disabled after reset

    // 1-bit lanes, prescale 3, full word
    wr(2'd1, 32'd3);
    wr(2'd3, 32'hC3A5_1E0F);
    wr(2'd2, {16'd0, 8'd31, 8'd31});
    wr(2'd0, 32'b001);
    idle(420);
    wr(2'd3, 32'h1234_5678);   // R9 write mid-stream
    idle(200);

    // R3 stop and hold
    wr(2'd0, 32'b000);
    idle(30);

    // 2-bit lanes, prescale 0
    wr(2'd1, 32'd0);
    wr(2'd2, {16'd0, 8'd15, 8'd15});
    wr(2'd0, 32'b011);
    idle(80);
    // 4-bit lanes, prescale 1
    wr(2'd0, 32'b100);
    wr(2'd1, 32'd1);
    wr(2'd2, {16'd0, 8'd7, 8'd7});
    wr(2'd0, 32'b101);
    idle(80);
    // 8-bit lanes, prescale 2
    wr(2'd0, 32'b110);
    wr(2'd1, 32'd2);
    wr(2'd2, {16'd0, 8'd3, 8'd3});
    wr(2'd0, 32'b111);
    idle(60);

    // chained preset of four slices, 1-bit, prescale 0
    wr(2'd0, 32'b000);
    wr(2'd1, 32'd0);
    wr(2'd2, {16'd0, 8'd127, 8'd127});
    wr(2'd0, 32'b001);
    idle(300);

    // R10 exchange on every tick, shadow writes collide
    wr(2'd0, 32'b110);
    wr(2'd2, {16'd0, 8'd0, 8'd0});
    wr(2'd0, 32'b111);
    wr(2'd3, 32'hDEAD_BEEF);
    wr(2'd3, 32'h0BAD_F00D);
    idle(10);
    wr(2'd0, 32'b110);
    wr(2'd3, 32'h5555_AAAA);   // R9 write while idle
    idle(10);

    @(negedge clk);
    chk("R7 all exchanges seen", expQ.size(), 32'd0);
    run = 0;
    summary();
  end
endmodule